// File: doc/BRIEF.md
# Grain v1 Keystream Generator

This block is a bit-serial synchronous stream cipher core. It holds an 80-bit nonlinear shift register and an 80-bit linear shift register, and it combines taps from both into one keystream bit per step. A `start` strobe loads the key and IV. The core then runs a fixed 160-clock warm-up in which each output bit is folded back into both feedback paths. After that it delivers keystream, and it advances one bit on every clock in which `advance` is high.

A small state machine sequences the core. It has three states:
- `ST_IDLE` is the state after reset.
- `ST_INIT` is the warm-up phase.
- `ST_GEN` is keystream generation.

It has three named transitions:
- T_LOAD goes from `ST_IDLE` to `ST_INIT` on `start`.
- T_DONE goes from `ST_INIT` to `ST_GEN` when the warm-up count finishes.
- T_RESTART goes from `ST_INIT` or `ST_GEN` back to `ST_INIT` on `start`.

Otherwise the state holds. A build-time parameter `HARDENED` swaps the five-input output filter for a variant that resists affine differentials. The hardened filter reads the same taps.

Top module: `grain_keystream_core`

## Requirements
- R1: A `start` in any state loads the NFSR with `key` (key bit i into NFSR bit i). It loads LFSR bits 0..63 with `iv` (iv bit i into LFSR bit i) and sets LFSR bits 64..79 to one. The core then enters `ST_INIT` with its count cleared. `start` takes priority over any step in that clock.
- R2: On each step both registers move toward index 0, and the new bit enters at index 79. The LFSR feedback is y0^y13^y23^y38^y51^y62, XORed with z during warm-up.
- R3: The NFSR feedback is y0 ^ g(x), XORed with z during warm-up. g is the XOR of these linear taps: x0, x9, x14, x21, x28, x33, x37, x45, x52, x60, x62. It also XORs these products: x63x60, x37x33, x15x9, x60x52x45, x33x28x21, x63x45x28x9, x60x52x37x33, x63x60x21x15, x63x60x52x45x37, x33x28x21x15x9, x52x45x37x33x28x21.
- R4: `ks_bit` is x1^x2^x4^x10^x31^x43^x56^h of the current state. h takes a=y3, b=y25, c=y46, d=y64, e=x63 and is b^e^ad^cd^de^abc^acd^ace^bce^cde.
- R5: Warm-up makes exactly 160 steps, one per clock, whatever the level of `advance`. `ks_valid` is low throughout warm-up and rises on the clock after the 160th step.
- R6: In `ST_GEN`, z is no longer fed back and `ks_valid` is high. The registers step only on clocks where `advance` is high; on other clocks they hold and `ks_bit` stays unchanged.
- R7: `ready` is low exactly while the core is in `ST_INIT`.
- R8: With `HARDENED`=1, h is replaced by the XOR of all ten pairwise products of a..e plus abd, bce, acd, bde, ace. The taps are unchanged.
- R9: After reset the core is in `ST_IDLE` with both registers zero. `ks_valid` is 0, `ready` is 1, and `ks_bit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load key/IV and begin warm-up |
| key | input | 80 | Secret key |
| iv | input | 64 | Initial value |
| advance | input | 1 | Step the keystream during generation |
| ks_bit | output | 1 | Current keystream bit |
| ks_valid | output | 1 | Keystream bits are valid |
| ready | output | 1 | Low while warm-up runs |

## Verification
The hardest situation to reach from the ports is a `start` that lands partway through warm-up or during a generation stall. Here the count has to restart cleanly, and the feedback mode has to flip at exactly the right step. The stimulus restarts the core 50 clocks into a warm-up. It also restarts the core during a stretch of generation with `advance` low. A behavioural model of both filter variants is compared bit by bit on every clock, so an off-by-one in the 160-step count or a wrong mode shows up within a few bits.

// File: rtl/grain_pkg.sv
package grain_pkg;
    localparam int unsigned REG_W = 80;
    localparam int unsigned IV_W  = 64;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_INIT = 2'd1,
        ST_GEN  = 2'd2
    } grain_state_e;
endpackage

// File: rtl/grain_ctrl.sv
module grain_ctrl
    import grain_pkg::*;
#(
    parameter int unsigned INIT_CLKS = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic advance,
    output logic load_o,
    output logic step_o,
    output logic fb_en_o,
    output logic valid_o,
    output logic ready_o
);
    localparam int unsigned CW = $clog2(INIT_CLKS + 1);
    localparam logic [CW-1:0] LAST = CW'(INIT_CLKS - 1);

    grain_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (start) begin
            state_d = ST_INIT;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_INIT: begin
                    if (cnt_q == LAST) begin
                        state_d = ST_GEN;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_GEN: ;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        load_o  = start;
        step_o  = 1'b0;
        fb_en_o = 1'b0;
        valid_o = 1'b0;
        ready_o = 1'b1;
        unique case (state_q)
            ST_IDLE: ;
            ST_INIT: begin
                step_o  = !start;
                fb_en_o = 1'b1;
                ready_o = 1'b0;
            end
            ST_GEN: begin
                step_o  = advance && !start;
                valid_o = 1'b1;
            end
            default: ;
        endcase
    end

    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    a_r5_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT && !start && cnt_q == LAST) |=> state_q == ST_GEN);
endmodule

// File: rtl/grain_filter.sv
module grain_filter
    import grain_pkg::*;
#(
    parameter bit HARDENED = 1'b0
) (
    input  logic [REG_W-1:0] x,
    input  logic [REG_W-1:0] y,
    output logic             z
);
    logic a, b, c, d, e, nl, lin;
    logic unused_bits;

    assign a = y[3];
    assign b = y[25];
    assign c = y[46];
    assign d = y[64];
    assign e = x[63];
    assign lin = x[1] ^ x[2] ^ x[4] ^ x[10] ^ x[31] ^ x[43] ^ x[56];
    assign unused_bits = ^{x, y};

    generate
        if (HARDENED) begin : g_hard
            assign nl = (a & b) ^ (b & c) ^ (c & d) ^ (d & e) ^ (e & a)
                      ^ (a & c) ^ (b & d) ^ (c & e) ^ (d & a) ^ (e & b)
                      ^ (a & b & d) ^ (b & c & e) ^ (c & d & a)
                      ^ (d & e & b) ^ (e & a & c);
        end else begin : g_plain
            assign nl = b ^ e ^ (a & d) ^ (c & d) ^ (d & e) ^ (a & b & c)
                      ^ (a & c & d) ^ (a & c & e) ^ (b & c & e) ^ (c & d & e);
        end
    endgenerate

    assign z = lin ^ nl;
endmodule

// File: rtl/grain_feedback.sv
module grain_feedback
    import grain_pkg::*;
(
    input  logic [REG_W-1:0] x,
    input  logic [REG_W-1:0] y,
    input  logic             z,
    input  logic             fb_en,
    output logic             x_new,
    output logic             y_new
);
    logic g, lfb, zf;
    logic unused_bits;

    assign unused_bits = ^{x, y};
    assign zf = z & fb_en;

    assign lfb = y[62] ^ y[51] ^ y[38] ^ y[23] ^ y[13] ^ y[0];

    assign g = x[62] ^ x[60] ^ x[52] ^ x[45] ^ x[37] ^ x[33] ^ x[28] ^ x[21]
             ^ x[14] ^ x[9] ^ x[0]
             ^ (x[63] & x[60]) ^ (x[37] & x[33]) ^ (x[15] & x[9])
             ^ (x[60] & x[52] & x[45]) ^ (x[33] & x[28] & x[21])
             ^ (x[63] & x[45] & x[28] & x[9])
             ^ (x[60] & x[52] & x[37] & x[33])
             ^ (x[63] & x[60] & x[21] & x[15])
             ^ (x[63] & x[60] & x[52] & x[45] & x[37])
             ^ (x[33] & x[28] & x[21] & x[15] & x[9])
             ^ (x[52] & x[45] & x[37] & x[33] & x[28] & x[21]);

    assign y_new = lfb ^ zf;
    assign x_new = y[0] ^ g ^ zf;
endmodule

// File: rtl/grain_keystream_core.sv
module grain_keystream_core
    import grain_pkg::*;
#(
    parameter bit          HARDENED  = 1'b0,
    parameter int unsigned INIT_CLKS = 2 * REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REG_W-1:0] key,
    input  logic [IV_W-1:0]  iv,
    input  logic             advance,
    output logic             ks_bit,
    output logic             ks_valid,
    output logic             ready
);
    localparam int unsigned PAD_W = REG_W - IV_W;

    logic [REG_W-1:0] nfsr_q, lfsr_q;
    logic load, step, fb_en, z, x_new, y_new;

    grain_ctrl #(.INIT_CLKS(INIT_CLKS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .advance (advance),
        .load_o  (load),
        .step_o  (step),
        .fb_en_o (fb_en),
        .valid_o (ks_valid),
        .ready_o (ready)
    );

    grain_filter #(.HARDENED(HARDENED)) u_filter (
        .x (nfsr_q),
        .y (lfsr_q),
        .z (z)
    );

    grain_feedback u_fb (
        .x     (nfsr_q),
        .y     (lfsr_q),
        .z     (z),
        .fb_en (fb_en),
        .x_new (x_new),
        .y_new (y_new)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nfsr_q <= '0;
            lfsr_q <= '0;
        end else if (load) begin
            nfsr_q <= key;
            lfsr_q <= {{PAD_W{1'b1}}, iv};
        end else if (step) begin
            nfsr_q <= {x_new, nfsr_q[REG_W-1:1]};
            lfsr_q <= {y_new, lfsr_q[REG_W-1:1]};
        end
    end

    assign ks_bit = z;

    a_r1_load_pad: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (lfsr_q[REG_W-1:IV_W] == {PAD_W{1'b1}}) && (nfsr_q == $past(key))
                  && (lfsr_q[IV_W-1:0] == $past(iv)));
    a_r5_no_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ks_valid && !ready);
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_valid && !advance && !start) |=> $stable(lfsr_q) && $stable(nfsr_q) && ks_valid);
    a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_valid && advance && !start)
            |=> lfsr_q[REG_W-2:0] == $past(lfsr_q[REG_W-1:1])
                && nfsr_q[REG_W-2:0] == $past(nfsr_q[REG_W-1:1]));
    a_r7_valid_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ks_valid |-> ready);
endmodule

// File: tb/test_grain_keystream_core.sv
`timescale 1ns/1ps
module test_grain_keystream_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [79:0] key = '0;
    logic [63:0] iv = '0;
    logic        advance = 1'b0;
    logic        ks0, val0, rdy0, ks1, val1, rdy1;

    int vectors = 0;
    int misses  = 0;
    int cyc     = 0;
    string cur_req = "R9";

    always #2 clk = ~clk;

    grain_keystream_core #(.HARDENED(1'b0)) i_grain_keystream_core (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key), .iv(iv),
        .advance(advance), .ks_bit(ks0), .ks_valid(val0), .ready(rdy0));

    grain_keystream_core #(.HARDENED(1'b1)) i_grain_keystream_core_hard (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key), .iv(iv),
        .advance(advance), .ks_bit(ks1), .ks_valid(val1), .ready(rdy1));

    // behavioural reference: index i of a vector is register bit i
    bit [79:0] mx [2];
    bit [79:0] my [2];
    int        mphase = 0;   // 0 idle, 1 warm-up, 2 generation
    int        msteps = 0;

    function automatic bit ref_z(bit [79:0] x, bit [79:0] y, bit hard);
        bit a, b, c, d, e, f;
        a = y[3]; b = y[25]; c = y[46]; d = y[64]; e = x[63];
        if (hard)
            f = (a&b)^(b&c)^(c&d)^(d&e)^(e&a)^(a&c)^(b&d)^(c&e)^(d&a)^(e&b)
              ^(a&b&d)^(b&c&e)^(c&d&a)^(d&e&b)^(e&a&c);
        else
            f = b^e^(a&d)^(c&d)^(d&e)^(a&b&c)^(a&c&d)^(a&c&e)^(b&c&e)^(c&d&e);
        return f ^ x[1]^x[2]^x[4]^x[10]^x[31]^x[43]^x[56];
    endfunction

    function automatic bit ref_g(bit [79:0] x);
        bit r;
        r = x[62]^x[60]^x[52]^x[45]^x[37]^x[33]^x[28]^x[21]^x[14]^x[9]^x[0];
        r ^= x[63]&x[60];
        r ^= x[37]&x[33];
        r ^= x[15]&x[9];
        r ^= x[60]&x[52]&x[45];
        r ^= x[33]&x[28]&x[21];
        r ^= x[63]&x[45]&x[28]&x[9];
        r ^= x[60]&x[52]&x[37]&x[33];
        r ^= x[63]&x[60]&x[21]&x[15];
        r ^= x[63]&x[60]&x[52]&x[45]&x[37];
        r ^= x[33]&x[28]&x[21]&x[15]&x[9];
        r ^= x[52]&x[45]&x[37]&x[33]&x[28]&x[21];
        return r;
    endfunction

    task automatic ref_step(int k, bit fb);
        bit zz, nx, ny;
        zz = ref_z(mx[k], my[k], k == 1) & fb;
        ny = my[k][0]^my[k][13]^my[k][23]^my[k][38]^my[k][51]^my[k][62]^zz;
        nx = my[k][0] ^ ref_g(mx[k]) ^ zz;
        mx[k] = {nx, mx[k][79:1]};
        my[k] = {ny, my[k][79:1]};
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            mphase = 0; msteps = 0;
            for (int k = 0; k < 2; k++) begin mx[k] = '0; my[k] = '0; end
        end else if (start) begin
            mphase = 1; msteps = 0;
            for (int k = 0; k < 2; k++) begin mx[k] = key; my[k] = {16'hFFFF, iv}; end
        end else if (mphase == 1) begin
            for (int k = 0; k < 2; k++) ref_step(k, 1'b1);
            msteps++;
            if (msteps == 160) mphase = 2;
        end else if (mphase == 2 && advance) begin
            for (int k = 0; k < 2; k++) ref_step(k, 1'b0);
        end
        if (cyc > 150000) begin
            misses++;
            $display("FAIL all watchdog expired: actual cycle %0d expected below 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    task automatic check(string req, string what, bit act, bit exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        check(cur_req, "plain ks_bit (R4)", ks0, ref_z(mx[0], my[0], 1'b0));
        check(cur_req, "hardened ks_bit (R8)", ks1, ref_z(mx[1], my[1], 1'b1));
        check(cur_req, "ks_valid (R5)", val0, mphase == 2);
        check(cur_req, "ks_valid hardened", val1, mphase == 2);
        check(cur_req, "ready (R7)", rdy0, mphase != 1);
        check(cur_req, "ready hardened", rdy1, mphase != 1);
    end

    task automatic pulse_start(logic [79:0] k, logic [63:0] v);
        key = k; iv = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        cur_req = "R9";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R3 R5: warm-up ignores advance
        cur_req = "R1";
        pulse_start(80'h0123_4567_89AB_CDEF_1234, 64'h0123_4567_89AB_CDEF);
        cur_req = "R5";
        advance = 1'b0;
        repeat (80) @(negedge clk);
        advance = 1'b1;
        repeat (85) @(negedge clk);
        // R6: generation with an irregular advance pattern, R2 R3 R4 exercised
        cur_req = "R6";
        for (int i = 0; i < 300; i++) begin
            advance = (i % 3 != 0);
            @(negedge clk);
        end
        // R1: restart during a stall in generation
        advance = 1'b0;
        repeat (5) @(negedge clk);
        cur_req = "R1";
        pulse_start(80'hFFFF_FFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        repeat (50) @(negedge clk);
        // restart partway through warm-up
        pulse_start(80'h8000_0000_0000_0000_0001, 64'h5A5A_A5A5_0F0F_F0F0);
        cur_req = "R5";
        repeat (170) @(negedge clk);
        cur_req = "R2";
        advance = 1'b1;
        repeat (200) @(negedge clk);
        // all-zero key and IV, R3 R8
        cur_req = "R3";
        pulse_start('0, '0);
        repeat (165) @(negedge clk);
        cur_req = "R8";
        for (int i = 0; i < 200; i++) begin
            advance = (i % 5 != 2);
            @(negedge clk);
        end
        // reset mid-run returns to idle
        cur_req = "R9";
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule